// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Access Rights

This block is a small, fully associative address translation buffer whose contents are managed entirely by software through three privileged commands: add a mapping, remove the mapping for a virtual page, and flush. Nothing is ever filled automatically. A combinational lookup port takes a virtual address, the kind of access (read, write or execute) and whether the requester runs in kernel or user mode. It returns either the translated physical address or a fault code that tells a missing mapping apart from a rights violation.

Slot 0 holds a permanent default mapping. It maps virtual page 0 to physical page 0 and grants read, write and execute to the kernel only. No command can alter or delete it. The other slots are filled by add commands. An add to a page that is already mapped rewrites that entry. Otherwise the add takes the lowest free slot, and when no slot is free it evicts an entry chosen round-robin.

Top module: `sw_tlb`

## Requirements
- R1: After reset only the default entry is present. A kernel read of an address in virtual page 0 returns the same offset as the physical address, and any other page misses.
- R2: The default entry maps page 0 to page 0 with kernel read, write and execute rights and no user rights. Add, remove and flush commands that name virtual page 0 leave it unchanged, and a flush never deletes it.
- R3: A lookup that hits and is permitted drives `lk_fault`=0 and `lk_cause`=0. The physical address is the entry's physical page number placed above the untranslated page-offset bits of the virtual address.
- R4: A lookup whose virtual page matches no entry drives `lk_fault`=1, `lk_cause`=2'b01 (not present) and `lk_paddr`=0.
- R5: The rights field `cmd_flags` has bit 5 kernel-execute, bit 4 kernel-write, bit 3 kernel-read, bit 2 user-execute, bit 1 user-write and bit 0 user-read. `lk_access` is 2'b00 for read, 2'b01 for write and 2'b10 for execute. A hit whose rights bit for that mode and access is 0 drives `lk_fault`=1, `lk_cause`=2'b10 (rights violation) and `lk_paddr`=0.
- R6: A remove command deletes the entry whose virtual page matches `cmd_vaddr`, and later lookups of that page miss.
- R7: A flush deletes every entry except the default one.
- R8: An add to a virtual page that is already present rewrites that entry's physical page and rights in place, without taking a second slot.
- R9: An add to a new page fills the lowest-numbered free slot. When every slot is full, it replaces the slot named by a round-robin pointer that runs over slots 1 to ENTRIES-1. The pointer starts at 1 after reset and advances only when a replacement happens.
- R10: Commands take effect at the rising clock edge. A lookup in the same cycle as a command sees the contents from before the command.
- R11: When several commands are asserted together, only one acts: flush wins over remove, and remove wins over add.
- R12: Access code 2'b11 is reserved. A lookup with this code always faults: it gives cause 2'b10 on a hit and 2'b01 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_add | input | 1 | Add or rewrite a mapping |
| cmd_remove | input | 1 | Remove the mapping of `cmd_vaddr` |
| cmd_flush | input | 1 | Remove all mappings except the default |
| cmd_vaddr | input | VA_W | Virtual address for add and remove |
| cmd_paddr | input | PA_W | Physical address for add (page bits used) |
| cmd_flags | input | 6 | Rights for add |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_kernel | input | 1 | 1 for kernel mode, 0 for user mode |
| lk_paddr | output | PA_W | Translated physical address, 0 on fault |
| lk_fault | output | 1 | Lookup faulted |
| lk_cause | output | 2 | 0 none, 1 not present, 2 rights violation |

## Verification
The bench builds the block with four slots, 16-bit virtual and 20-bit physical addresses and 256-byte pages. With only three replaceable slots, a handful of adds fills the buffer. This brings eviction order, pointer wrap-around and the interaction of remove with lowest-free-slot reuse into reach within a few cycles. Drawing random traffic from a narrow range of virtual pages keeps hits, misses, rewrites and collisions with page 0 frequent.

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_add,
  input  logic            cmd_remove,
  input  logic            cmd_flush,
  input  logic [VA_W-1:0] cmd_vaddr,
  input  logic [PA_W-1:0] cmd_paddr,
  input  logic [5:0]      cmd_flags,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic [1:0]      lk_access,
  input  logic            lk_kernel,
  output logic [PA_W-1:0] lk_paddr,
  output logic            lk_fault,
  output logic [1:0]      lk_cause
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IW    = (ENTRIES > 2) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic             e_vld [ENTRIES];
  logic [VPN_W-1:0] e_vpn [ENTRIES];
  logic [PPN_W-1:0] e_ppn [ENTRIES];
  logic [5:0]       e_flg [ENTRIES];
  logic [IW-1:0]    rr;

  wire [VPN_W-1:0] c_vpn = cmd_vaddr[VA_W-1:PAGE_BITS];
  wire [VPN_W-1:0] l_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

  logic          cm_hit, fr_any;
  logic [IW-1:0] cm_idx, fr_idx, w_idx;

  always_comb begin
    cm_hit = 1'b0; cm_idx = '0; fr_any = 1'b0; fr_idx = '0;
    for (int i = ENTRIES - 1; i >= 1; i--) begin
      if (e_vld[i] && e_vpn[i] == c_vpn) begin
        cm_hit = 1'b1; cm_idx = IW'(i);
      end
      if (!e_vld[i]) begin
        fr_any = 1'b1; fr_idx = IW'(i);
      end
    end
  end

  assign w_idx = cm_hit ? cm_idx : (fr_any ? fr_idx : rr);
  wire do_add = cmd_add && !cmd_remove && !cmd_flush && (c_vpn != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vld[i] <= (i == 0);
        e_vpn[i] <= '0;
        e_ppn[i] <= '0;
        e_flg[i] <= (i == 0) ? 6'b111000 : 6'b000000;
      end
      rr <= IW'(1);
    end else if (cmd_flush) begin
      for (int i = 1; i < ENTRIES; i++) e_vld[i] <= 1'b0;
    end else if (cmd_remove) begin
      if (cm_hit) e_vld[cm_idx] <= 1'b0;
    end else if (do_add) begin
      e_vld[w_idx] <= 1'b1;
      e_vpn[w_idx] <= c_vpn;
      e_ppn[w_idx] <= cmd_paddr[PA_W-1:PAGE_BITS];
      e_flg[w_idx] <= cmd_flags;
      if (!cm_hit && !fr_any) rr <= (rr == LAST) ? IW'(1) : rr + IW'(1);
    end
  end

  logic             l_hit;
  logic [PPN_W-1:0] l_ppn;
  logic [5:0]       l_flg;

  always_comb begin
    l_hit = 1'b0; l_ppn = '0; l_flg = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (e_vld[i] && e_vpn[i] == l_vpn) begin
        l_hit = 1'b1; l_ppn = e_ppn[i]; l_flg = e_flg[i];
      end
  end

  wire [2:0] sel   = {1'b0, lk_access} + (lk_kernel ? 3'd3 : 3'd0);
  wire [7:0] fx    = {2'b00, l_flg};
  wire       ok    = (lk_access != 2'b11) && fx[sel];

  assign lk_fault = !(l_hit && ok);
  assign lk_cause = !l_hit ? 2'b01 : (ok ? 2'b00 : 2'b10);
  assign lk_paddr = lk_fault ? '0 : {l_ppn, lk_vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/sw_tlb_checker.sv
module sw_tlb_checker #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_add,
  input logic            cmd_remove,
  input logic            cmd_flush,
  input logic [VA_W-1:0] cmd_vaddr,
  input logic [PA_W-1:0] cmd_paddr,
  input logic [5:0]      cmd_flags,
  input logic [VA_W-1:0] lk_vaddr,
  input logic [1:0]      lk_access,
  input logic            lk_kernel,
  input logic [PA_W-1:0] lk_paddr,
  input logic            lk_fault,
  input logic [1:0]      lk_cause
);
  wire lk_pg0  = lk_vaddr[VA_W-1:PAGE_BITS] == '0;
  wire cmd_pg0 = cmd_vaddr[VA_W-1:PAGE_BITS] == '0;

  assert_cause_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_cause == 2'b01 || lk_cause == 2'b10));

  assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_paddr == '0);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fault |-> (lk_cause == 2'b00 &&
                   lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

  assert_default_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pg0 && lk_kernel && lk_access != 2'b11) |->
      (!lk_fault && lk_paddr == PA_W'(lk_vaddr[PAGE_BITS-1:0])));

  assert_default_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pg0 && !lk_kernel) |-> lk_cause == 2'b10);

  assert_reserved_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_access == 2'b11) |-> lk_fault);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (lk_pg0 || lk_cause == 2'b01));

  assert_remove_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_remove && !cmd_flush && !cmd_pg0) |=>
      (lk_vaddr[VA_W-1:PAGE_BITS] != $past(cmd_vaddr[VA_W-1:PAGE_BITS]) ||
       lk_cause == 2'b01));
endmodule

bind sw_tlb sw_tlb_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) u_chk (.*);

// File: tb/sw_tlb_bench.sv
module sw_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 16, PA_W = 20, PB = 8, N = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_add = 0, cmd_remove = 0, cmd_flush = 0;
  logic [VA_W-1:0] cmd_vaddr = '0, lk_vaddr = '0;
  logic [PA_W-1:0] cmd_paddr = '0;
  logic [5:0] cmd_flags = '0;
  logic [1:0] lk_access = '0;
  logic lk_kernel = 0;
  logic [PA_W-1:0] lk_paddr;
  logic lk_fault;
  logic [1:0] lk_cause;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_tlb #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .ENTRIES(N)) u_sw_tlb (.*);

  int m_vld[N], m_vpn[N], m_ppn[N], m_flg[N], m_rr;

  function automatic int find(int vpn);
    for (int i = 1; i < N; i++) if (m_vld[i] != 0 && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_flg[i] = 0; end
    m_rr = 1;
  endfunction

  function automatic void m_update();
    int v, s, fr;
    v = int'(cmd_vaddr) >> PB;
    if (cmd_flush) begin
      for (int i = 1; i < N; i++) m_vld[i] = 0;
    end else if (cmd_remove) begin
      s = find(v);
      if (s > 0) m_vld[s] = 0;
    end else if (cmd_add && v != 0) begin
      s = find(v);
      if (s < 0) begin
        fr = -1;
        for (int i = N - 1; i >= 1; i--) if (m_vld[i] == 0) fr = i;
        if (fr > 0) s = fr;
        else begin s = m_rr; m_rr = (m_rr == N - 1) ? 1 : m_rr + 1; end
      end
      m_vld[s] = 1; m_vpn[s] = v; m_ppn[s] = int'(cmd_paddr) >> PB; m_flg[s] = int'(cmd_flags);
    end
  endfunction

  task automatic check(string tag);
    int v, s, ppn, flg, bitn;
    bit hit, ok;
    logic [PA_W-1:0] e_pa;
    logic e_f;
    logic [1:0] e_c;
    string t;
    v = int'(lk_vaddr) >> PB;
    hit = 0; ppn = 0; flg = 0;
    if (v == 0) begin hit = 1; ppn = 0; flg = 6'b111000; end
    else begin s = find(v); if (s > 0) begin hit = 1; ppn = m_ppn[s]; flg = m_flg[s]; end end
    bitn = int'(lk_access) + (lk_kernel ? 3 : 0);
    ok = hit && lk_access != 2'b11 && ((flg >> bitn) & 1) == 1;
    e_f = !ok;
    e_c = !hit ? 2'b01 : (ok ? 2'b00 : 2'b10);
    e_pa = ok ? PA_W'((ppn << PB) | (int'(lk_vaddr) & ((1 << PB) - 1))) : '0;
    t = tag;
    if (t == "") t = (lk_access == 2'b11) ? "R12" : (!hit ? "R4" : (ok ? "R3" : "R5"));
    checks++;
    if (lk_paddr !== e_pa || lk_fault !== e_f || lk_cause !== e_c) begin
      fails++;
      $display("FAIL %s: va=%h acc=%0d k=%0b actual pa=%h f=%0b c=%0d expected pa=%h f=%0b c=%0d",
               t, lk_vaddr, lk_access, lk_kernel, lk_paddr, lk_fault, lk_cause, e_pa, e_f, e_c);
    end
  endtask

  task automatic step(bit a, bit r, bit f, int cva, int cpa, int cfl,
                      int lva, int acc, bit k, string tag);
    cmd_add = a; cmd_remove = r; cmd_flush = f;
    cmd_vaddr = VA_W'(cva); cmd_paddr = PA_W'(cpa); cmd_flags = 6'(cfl);
    lk_vaddr = VA_W'(lva); lk_access = 2'(acc); lk_kernel = k;
    #(CLK_PERIOD/4);
    check(tag);
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic look(int lva, int acc, bit k, string tag);
    step(0, 0, 0, 0, 0, 0, lva, acc, k, tag);
  endtask

  task automatic add(int vpn, int ppn, int fl, string tag);
    step(1, 0, 0, vpn << PB, ppn << PB, fl, 0, 0, 1, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1; fails++;
        $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    look('h0034, 0, 1, "R1");
    look('h0134, 0, 1, "R1");
    // R2 default rights
    look('h0010, 0, 0, "R2");
    look('h0010, 2, 1, "R2");
    // R10 add with same-cycle lookup sees old contents
    step(1, 0, 0, 'h0100, 'hABC00, 6'b000001, 'h0155, 0, 0, "R10");
    look('h0155, 0, 0, "R3");
    look('h0155, 1, 0, "R5");
    look('h0155, 0, 1, "R5");
    // R8 rewrite in place
    add(1, 'h123, 6'b111111, "R8");
    look('h01AA, 1, 1, "R8");
    look('h01AA, 2, 0, "R8");
    // R9 fill then round-robin replacement
    add(2, 'h200, 6'b111111, "R9");
    add(3, 'h300, 6'b111111, "R9");
    add(4, 'h400, 6'b111111, "R9");
    look('h0101, 0, 1, "R9");
    look('h0401, 0, 1, "R9");
    add(5, 'h500, 6'b111111, "R9");
    look('h0201, 0, 1, "R9");
    look('h0301, 0, 1, "R9");
    // R6 remove, then lowest free slot reuse
    step(0, 1, 0, 'h0300, 0, 0, 'h0301, 0, 1, "R6");
    look('h0301, 0, 1, "R6");
    add(6, 'h600, 6'b111111, "R9");
    add(7, 'h700, 6'b111111, "R9");
    look('h0601, 0, 1, "R9");
    look('h0401, 0, 1, "R9");
    look('h0501, 0, 1, "R9");
    // R2 commands on page 0 are ignored
    step(0, 1, 0, 'h0000, 0, 0, 0, 0, 1, "R2");
    add(0, 'h777, 6'b000000, "R2");
    look('h0022, 0, 1, "R2");
    look('h0022, 0, 0, "R2");
    // R11 flush beats add, R7 flush clears
    step(1, 0, 1, 'h0800, 'h80000, 6'b111111, 0, 0, 1, "R11");
    look('h0801, 0, 1, "R11");
    look('h0401, 0, 1, "R7");
    look('h0701, 0, 1, "R7");
    look('h0005, 1, 1, "R7");
    // R11 remove beats add
    add(9, 'h900, 6'b111111, "R11");
    step(1, 1, 0, 'h0900, 'h90000, 6'b111111, 0, 0, 1, "R11");
    look('h0901, 0, 1, "R11");
    // R12 reserved access code
    add(10, 'hA00, 6'b111111, "R12");
    look('h0A01, 3, 1, "R12");
    look('h0B01, 3, 1, "R12");
    look('h0001, 3, 1, "R12");
    // random traffic over a narrow page range
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 25, r >= 25 && r < 33, r == 99 || (r >= 33 && r < 35 && n % 3 == 0),
           ($urandom_range(0, 9) << PB) | $urandom_range(0, 255),
           $urandom_range(0, 'hFFFFF), $urandom_range(0, 63),
           ($urandom_range(0, 9) << PB) | $urandom_range(0, 255),
           $urandom_range(0, 3), 1'($urandom_range(0, 1)), "");
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule